// File: doc/BRIEF.md
# Output Fault Retry Supervisor

This block decides, from a stream of fault flags, whether a supply's main output and its standby output may run. A fault shuts down the output it belongs to for a fixed off interval and then restarts that output on its own. Each such shutdown is counted. After the allowed number of restarts has been used, the next fault latches the outputs off until software or the system takes them through a clear. A main-output fault stops only the main output. A standby fault or an over-temperature event stops both outputs.

Standby overcurrent takes a separate path. It switches standby off for a short hiccup interval and then tries again, with no limit and without touching the restart counter. Main overcurrent must persist through a blanking window before it counts as a fault. A main short circuit is accepted after a shorter window. All fault inputs and all timers advance only on a millisecond tick, so every interval is a count of ticks.

Top module: `fault_supervisor`

## Requirements
- R1: When the main output is on, a tick with `main_ov` or `main_uv` high, or a qualified overcurrent or short, turns `main_en` off for exactly `RETRY_OFF_MS` ticks. `main_en` then returns by itself. `sb_en` stays on throughout.
- R2: When standby is on, a tick with `sb_ov`, `sb_uv` or `over_temp` high turns both `main_en` and `sb_en` off for exactly `RETRY_OFF_MS` ticks. Both then return together.
- R3: Each fault shutdown raises `retry_count` by one. A fault that arrives while `retry_count` equals `MAX_RETRY` (default 5) does not restart. Instead it sets `fault_latched`, leaves `retry_count` at `MAX_RETRY`, and keeps the outputs off for as long as no clear occurs. A main-only latch keeps standby on. A standby latch keeps both outputs off.
- R4: A falling edge on `out_enable` clears `fault_latched` and `retry_count` to 0. Raising `out_enable` again restarts the main output.
- R5: While `pwr_ok` is low, both outputs are off and the counter and the latch are cleared. When `pwr_ok` returns, both outputs come back on the next cycle.
- R6: While `out_enable` is low, `main_en` is off and `sb_en` stays on.
- R7: When standby is on, a tick with `sb_oc` high turns only `sb_en` off, for exactly `HICCUP_OFF_MS` ticks. While the overload persists this repeats without limit. `retry_count` and `main_en` are unaffected.
- R8: `main_oc` is treated as a fault only on the tick where it has been high on `OC_BLANK_MS`+1 consecutive ticks. A low tick restarts the count.
- R9: `main_short` is treated as a fault on the `SHORT_MS`-th consecutive tick on which it is high.
- R10: Without `ms_tick`, fault flags have no effect and the off intervals do not advance.
- R11: During reset, `main_en`, `sb_en` and `fault_latched` are 0 and `retry_count` is 0. On the cycle after reset is released with power valid and enable high, both outputs come on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| pwr_ok | input | 1 | Input power within operating range |
| out_enable | input | 1 | Main output enable request; its falling edge clears the latch |
| main_ov | input | 1 | Main output overvoltage |
| main_uv | input | 1 | Main output undervoltage |
| main_oc | input | 1 | Main static overcurrent (before blanking) |
| main_short | input | 1 | Main output below short-circuit level |
| over_temp | input | 1 | Over-temperature (shuts both outputs) |
| sb_ov | input | 1 | Standby overvoltage |
| sb_uv | input | 1 | Standby undervoltage |
| sb_oc | input | 1 | Standby overcurrent (hiccup path) |
| main_en | output | 1 | Main output enable |
| sb_en | output | 1 | Standby output enable |
| fault_latched | output | 1 | Outputs latched off after the retry limit |
| retry_count | output | $clog2(MAX_RETRY+1) | Fault shutdowns since last clear |

## Verification
The hardest state to reach is the latch-off. It needs six separate fault shutdowns, and each one must wait through the full off interval so that the next fault finds its output running again. The latch must also be reached once through the main-only scope and once through the standby scope. The bench shrinks the off intervals through parameters. It pulses one fault flag for a single tick and then waits for the output to come back before sending the next pulse. This drives the counter up to its limit and then over it. It also holds `ms_tick` low in the middle of an off interval to show that the interval freezes.

// File: rtl/fsup_pkg.sv
`timescale 1ns/1ps
package fsup_pkg;

  // Retry controller states: running, timed off (main only / both),
  // latched off (main only / both).
  typedef enum logic [2:0] {
    ST_RUN,
    ST_OFF_MAIN,
    ST_OFF_ALL,
    ST_LATCH_MAIN,
    ST_LATCH_ALL
  } fsup_state_e;

endpackage

// File: rtl/fsup_off_timer.sv
`timescale 1ns/1ps
// Tick-driven off interval: load starts a count of OFF_TICKS ticks,
// done pulses on the tick that ends it.
module fsup_off_timer #(
  parameter int unsigned OFF_TICKS = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  input  logic load,
  output logic done
);
  localparam int unsigned TW = $clog2(OFF_TICKS + 1);
  localparam logic [TW-1:0] TMAX = TW'(OFF_TICKS);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= TMAX;
    end else if (tick && cnt_q != '0) begin
      cnt_q <= cnt_q - TW'(1);
    end
  end

  assign done = tick && (cnt_q == TW'(1));

  // R1: the interval never holds more than its configured length
  a_r1_timer_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= TMAX);

  // R10: without a tick the remaining interval is frozen
  a_r10_timer_frozen: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/fsup_persist.sv
`timescale 1ns/1ps
// Persistence filter: hit fires on the LIMIT-th consecutive tick on
// which flag is high while armed. A low tick or disarm restarts it.
module fsup_persist #(
  parameter int unsigned LIMIT = 21
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic arm,
  input  logic flag,
  output logic hit
);
  localparam int unsigned PW = $clog2(LIMIT + 1);
  localparam logic [PW-1:0] LAST = PW'(LIMIT - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !arm) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (!flag) begin
        cnt_q <= '0;
      end else if (cnt_q != LAST) begin
        cnt_q <= cnt_q + PW'(1);
      end
    end
  end

  assign hit = arm && tick && flag && (cnt_q == LAST);

  // R8: a low sample restarts the persistence window
  a_r8_drop_restarts: assert property (@(posedge clk) disable iff (rst)
    (tick && !flag) |=> (cnt_q == '0));

  // R8: the count never runs past the qualifying sample
  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

endmodule

// File: rtl/fsup_hiccup.sv
`timescale 1ns/1ps
// Standby overcurrent hiccup: drop standby for OFF_TICKS ticks, then
// retry; no limit, no counting.
module fsup_hiccup #(
  parameter int unsigned OFF_TICKS = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic pwr_ok,
  input  logic sb_up,
  input  logic oc_flag,
  output logic hic_off
);
  logic hic_q;
  logic trip;
  logic done;

  assign trip = tick && oc_flag && sb_up && !hic_q && pwr_ok;

  fsup_off_timer #(.OFF_TICKS(OFF_TICKS)) u_hic_tmr (
    .clk  (clk),
    .rst  (rst),
    .clr  (!pwr_ok),
    .tick (tick),
    .load (trip),
    .done (done)
  );

  always_ff @(posedge clk) begin
    if (rst || !pwr_ok) begin
      hic_q <= 1'b0;
    end else if (trip) begin
      hic_q <= 1'b1;
    end else if (done && hic_q) begin
      hic_q <= 1'b0;
    end
  end

  assign hic_off = hic_q;

  // R7: an overcurrent sample on a live standby starts the off interval
  a_r7_trip_offs: assert property (@(posedge clk) disable iff (rst)
    trip |=> hic_q);

  // R7: the hiccup off state only ends when its interval expires
  a_r7_off_holds: assert property (@(posedge clk) disable iff (rst)
    (hic_q && !done && pwr_ok) |=> hic_q);

endmodule

// File: rtl/fsup_retry_fsm.sv
`timescale 1ns/1ps
// Counted auto-retry with latch-off and per-output fault scope.
module fsup_retry_fsm
  import fsup_pkg::*;
#(
  parameter int unsigned OFF_TICKS = 10000,
  parameter int unsigned MAX_RETRY = 5,
  localparam int unsigned CW = $clog2(MAX_RETRY + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          pwr_ok,
  input  logic          enable,
  input  logic          main_flt,
  input  logic          sb_flt,
  input  logic          sb_live,
  output logic          main_on,
  output logic          sb_on,
  output logic          latched,
  output logic [CW-1:0] retry_cnt
);
  localparam logic [CW-1:0] CMAX = CW'(MAX_RETRY);

  fsup_state_e   st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en_q, main_q, sb_q;
  logic          en_fall, clear, load, done;
  logic          main_hit, sb_hit, at_limit;

  assign en_fall  = en_q && !enable;
  assign clear    = !pwr_ok || en_fall;
  assign main_hit = tick && main_flt && main_q;
  assign sb_hit   = tick && sb_flt && sb_live;
  assign at_limit = (cnt_q == CMAX);

  fsup_off_timer #(.OFF_TICKS(OFF_TICKS)) u_retry_tmr (
    .clk  (clk),
    .rst  (rst),
    .clr  (clear),
    .tick (tick),
    .load (load),
    .done (done)
  );

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    load  = 1'b0;
    if (clear) begin
      st_d  = ST_RUN;
      cnt_d = '0;
    end else begin
      case (st_q)
        ST_RUN, ST_OFF_MAIN: begin
          if (sb_hit) begin
            if (at_limit) begin
              st_d = ST_LATCH_ALL;
            end else begin
              st_d  = ST_OFF_ALL;
              cnt_d = cnt_q + CW'(1);
              load  = 1'b1;
            end
          end else if (st_q == ST_RUN && main_hit) begin
            if (at_limit) begin
              st_d = ST_LATCH_MAIN;
            end else begin
              st_d  = ST_OFF_MAIN;
              cnt_d = cnt_q + CW'(1);
              load  = 1'b1;
            end
          end else if (st_q == ST_OFF_MAIN && done) begin
            st_d = ST_RUN;
          end
        end
        ST_OFF_ALL: begin
          if (done) st_d = ST_RUN;
        end
        ST_LATCH_MAIN: begin
          if (sb_hit) st_d = ST_LATCH_ALL;
        end
        default: begin
          st_d = st_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_RUN;
      cnt_q  <= '0;
      en_q   <= 1'b0;
      main_q <= 1'b0;
      sb_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      en_q   <= enable;
      main_q <= pwr_ok && enable && (st_d == ST_RUN);
      sb_q   <= pwr_ok && (st_d != ST_OFF_ALL) && (st_d != ST_LATCH_ALL);
    end
  end

  assign main_on   = main_q;
  assign sb_on     = sb_q;
  assign latched   = (st_q == ST_LATCH_MAIN) || (st_q == ST_LATCH_ALL);
  assign retry_cnt = cnt_q;

  // R3: the restart counter never passes its limit
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CMAX);

  // R3: a latch persists until a clear
  a_r3_latch_sticks: assert property (@(posedge clk) disable iff (rst)
    (latched && !clear) |=> latched);

  // R1: a counted main shutdown steps the counter and drops main
  a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && !clear && main_hit && !sb_hit && !at_limit)
      |=> (cnt_q == $past(cnt_q) + CW'(1)) && !main_on);

  // R1: standby keeps running during a main-only off interval
  a_r1_sb_kept: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_OFF_MAIN) |-> sb_on);

  // R2: a standby-scope shutdown holds both outputs off
  a_r2_all_off: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_OFF_ALL || st_q == ST_LATCH_ALL) |-> (!main_on && !sb_on));

  // R4: an enable falling edge clears the counter and the latch
  a_r4_enable_clear: assert property (@(posedge clk) disable iff (rst)
    en_fall |=> (cnt_q == '0) && !latched);

endmodule

// File: rtl/fault_supervisor.sv
`timescale 1ns/1ps
// Top: fault qualification, counted retry, standby hiccup.
module fault_supervisor #(
  parameter int unsigned RETRY_OFF_MS  = 10000,
  parameter int unsigned HICCUP_OFF_MS = 1000,
  parameter int unsigned OC_BLANK_MS   = 20,
  parameter int unsigned SHORT_MS      = 10,
  parameter int unsigned MAX_RETRY     = 5
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           ms_tick,
  input  logic                           pwr_ok,
  input  logic                           out_enable,
  input  logic                           main_ov,
  input  logic                           main_uv,
  input  logic                           main_oc,
  input  logic                           main_short,
  input  logic                           over_temp,
  input  logic                           sb_ov,
  input  logic                           sb_uv,
  input  logic                           sb_oc,
  output logic                           main_en,
  output logic                           sb_en,
  output logic                           fault_latched,
  output logic [$clog2(MAX_RETRY+1)-1:0] retry_count
);
  localparam int unsigned CW = $clog2(MAX_RETRY + 1);

  logic          oc_hit, short_hit;
  logic          main_flt, sb_flt;
  logic          main_on, sb_on, hic_off;
  logic [CW-1:0] cnt;
  logic          latched;

  // Static overcurrent must outlast the blanking window.
  fsup_persist #(.LIMIT(OC_BLANK_MS + 1)) u_oc_blank (
    .clk  (clk),
    .rst  (rst),
    .tick (ms_tick),
    .arm  (main_on),
    .flag (main_oc),
    .hit  (oc_hit)
  );

  // Short circuit qualifies after its own shorter window.
  fsup_persist #(.LIMIT(SHORT_MS)) u_short_qual (
    .clk  (clk),
    .rst  (rst),
    .tick (ms_tick),
    .arm  (main_on),
    .flag (main_short),
    .hit  (short_hit)
  );

  assign main_flt = main_ov || main_uv || oc_hit || short_hit;
  assign sb_flt   = sb_ov || sb_uv || over_temp;

  fsup_retry_fsm #(
    .OFF_TICKS (RETRY_OFF_MS),
    .MAX_RETRY (MAX_RETRY)
  ) u_retry (
    .clk       (clk),
    .rst       (rst),
    .tick      (ms_tick),
    .pwr_ok    (pwr_ok),
    .enable    (out_enable),
    .main_flt  (main_flt),
    .sb_flt    (sb_flt),
    .sb_live   (sb_en),
    .main_on   (main_on),
    .sb_on     (sb_on),
    .latched   (latched),
    .retry_cnt (cnt)
  );

  fsup_hiccup #(.OFF_TICKS(HICCUP_OFF_MS)) u_hiccup (
    .clk     (clk),
    .rst     (rst),
    .tick    (ms_tick),
    .pwr_ok  (pwr_ok),
    .sb_up   (sb_on),
    .oc_flag (sb_oc),
    .hic_off (hic_off)
  );

  assign main_en       = main_on;
  assign sb_en         = sb_on && !hic_off;
  assign fault_latched = latched;
  assign retry_count   = cnt;

  // R5: invalid input power drops both outputs and clears the counter
  a_r5_power_loss: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok |=> (!main_en && !sb_en && retry_count == '0));

  // R6: enable low keeps main off
  a_r6_enable_low: assert property (@(posedge clk) disable iff (rst)
    !out_enable |=> !main_en);

  // R7: a hiccup never touches the restart counter by itself
  a_r7_hiccup_uncounted: assert property (@(posedge clk) disable iff (rst)
    ($rose(hic_off) && !$past(ms_tick && (main_flt || sb_flt)) && $past(pwr_ok && out_enable) && $past(out_enable))
      |-> $stable(retry_count));

endmodule

// File: tb/test_fault_supervisor.sv
`timescale 1ns/1ps
module test_fault_supervisor;
  localparam int OFF   = 8;
  localparam int HIC   = 4;
  localparam int BLANK = 5;
  localparam int SHORT = 3;
  localparam int MAXR  = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, ms_tick, pwr_ok, out_enable;
  logic main_ov, main_uv, main_oc, main_short, over_temp;
  logic sb_ov, sb_uv, sb_oc;
  logic main_en, sb_en, fault_latched;
  logic [2:0] retry_count;

  int tests = 0;
  int fails = 0;

  fault_supervisor #(
    .RETRY_OFF_MS  (OFF),
    .HICCUP_OFF_MS (HIC),
    .OC_BLANK_MS   (BLANK),
    .SHORT_MS      (SHORT),
    .MAX_RETRY     (MAXR)
  ) i_fault_supervisor (
    .clk (clk), .rst (rst), .ms_tick (ms_tick), .pwr_ok (pwr_ok),
    .out_enable (out_enable), .main_ov (main_ov), .main_uv (main_uv),
    .main_oc (main_oc), .main_short (main_short), .over_temp (over_temp),
    .sb_ov (sb_ov), .sb_uv (sb_uv), .sb_oc (sb_oc),
    .main_en (main_en), .sb_en (sb_en), .fault_latched (fault_latched),
    .retry_count (retry_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_main_on;
    for (int g = 0; g < 500 && main_en !== 1'b1; g++) @(negedge clk);
  endtask

  task automatic wait_sb_on;
    for (int g = 0; g < 500 && sb_en !== 1'b1; g++) @(negedge clk);
  endtask

  // Called on a negedge where main_en is low; counts low samples.
  task automatic run_low_main(output int n);
    n = 1;
    while (main_en === 1'b0 && n < 500) begin
      @(negedge clk);
      if (main_en === 1'b0) n++;
    end
  endtask

  task automatic run_low_sb(output int n);
    n = 1;
    while (sb_en === 1'b0 && n < 500) begin
      @(negedge clk);
      if (sb_en === 1'b0) n++;
    end
  endtask

  // Called on the negedge a flag is raised; counts high samples after.
  task automatic run_high_main(output int n);
    n = 0;
    while (main_en === 1'b1 && n < 500) begin
      @(negedge clk);
      if (main_en === 1'b1) n++;
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; ms_tick = 1'b1; pwr_ok = 1'b1; out_enable = 1'b1;
    main_ov = 0; main_uv = 0; main_oc = 0; main_short = 0; over_temp = 0;
    sb_ov = 0; sb_uv = 0; sb_oc = 0;
    step(3);
    chk("R11 main_en in reset", main_en, 0);
    chk("R11 sb_en in reset", sb_en, 0);
    chk("R11 latch in reset", fault_latched, 0);
    chk("R11 count in reset", retry_count, 0);
    rst = 1'b0;
    step(1);
    chk("R11 main_en after reset", main_en, 1);
    chk("R11 sb_en after reset", sb_en, 1);
  endtask

  task automatic t_main_fault;
    int n;
    main_uv = 1'b1; step(1); main_uv = 1'b0;
    chk("R1 main off", main_en, 0);
    chk("R1 sb kept", sb_en, 1);
    chk("R3 count 1", retry_count, 1);
    run_low_main(n);
    chk("R1 off ticks", n, OFF);
    chk("R1 main back", main_en, 1);
    chk("R1 sb still on", sb_en, 1);
  endtask

  task automatic t_sb_fault;
    int n;
    over_temp = 1'b1; step(1); over_temp = 1'b0;
    chk("R2 main off", main_en, 0);
    chk("R2 sb off", sb_en, 0);
    chk("R3 count 2", retry_count, 2);
    run_low_sb(n);
    chk("R2 off ticks", n, OFF);
    chk("R2 main back with sb", main_en, 1);
  endtask

  task automatic t_main_latch;
    for (int k = 0; k < 3; k++) begin
      main_ov = 1'b1; step(1); main_ov = 1'b0;
      wait_main_on;
    end
    chk("R3 count at limit", retry_count, MAXR);
    main_ov = 1'b1; step(1); main_ov = 1'b0;
    chk("R3 latched", fault_latched, 1);
    chk("R3 main latched off", main_en, 0);
    chk("R3 main latch keeps sb", sb_en, 1);
    step(3 * OFF);
    chk("R3 main stays off", main_en, 0);
    chk("R3 count held", retry_count, MAXR);
  endtask

  task automatic t_enable_clear;
    out_enable = 1'b0; step(1);
    chk("R6 main off when disabled", main_en, 0);
    chk("R6 sb on when disabled", sb_en, 1);
    chk("R4 latch cleared", fault_latched, 0);
    chk("R4 count cleared", retry_count, 0);
    out_enable = 1'b1; step(1);
    chk("R4 main restarts", main_en, 1);
  endtask

  task automatic t_sb_latch;
    for (int k = 0; k < MAXR; k++) begin
      sb_ov = 1'b1; step(1); sb_ov = 1'b0;
      wait_sb_on;
      wait_main_on;
    end
    chk("R3 sb count at limit", retry_count, MAXR);
    sb_uv = 1'b1; step(1); sb_uv = 1'b0;
    chk("R3 sb latched", fault_latched, 1);
    chk("R3 sb latch main off", main_en, 0);
    chk("R3 sb latch sb off", sb_en, 0);
    step(3 * OFF);
    chk("R3 sb stays off", sb_en, 0);
    pwr_ok = 1'b0; step(1);
    chk("R5 main off", main_en, 0);
    chk("R5 sb off", sb_en, 0);
    chk("R5 count cleared", retry_count, 0);
    chk("R5 latch cleared", fault_latched, 0);
    pwr_ok = 1'b1; step(1);
    chk("R5 main back", main_en, 1);
    chk("R5 sb back", sb_en, 1);
  endtask

  task automatic t_hiccup;
    int n;
    int lows;
    sb_oc = 1'b1; step(1);
    chk("R7 sb off", sb_en, 0);
    chk("R7 main unaffected", main_en, 1);
    run_low_sb(n);
    chk("R7 hiccup ticks", n, HIC);
    chk("R7 sb retries", sb_en, 1);
    step(1);
    chk("R7 sb off again", sb_en, 0);
    run_low_sb(n);
    chk("R7 second hiccup ticks", n, HIC);
    chk("R7 not counted", retry_count, 0);
    chk("R7 main still on", main_en, 1);
    sb_oc = 1'b0;
    lows = 0;
    for (int i = 0; i < 2 * HIC; i++) begin
      step(1);
      if (sb_en !== 1'b1) lows++;
    end
    chk("R7 recovered", lows, 0);
  endtask

  task automatic t_oc_blank;
    int n;
    main_oc = 1'b1; step(BLANK); main_oc = 1'b0; step(1);
    main_oc = 1'b1; step(BLANK); main_oc = 1'b0; step(2);
    chk("R8 short pulses ignored", main_en, 1);
    chk("R8 no count", retry_count, 0);
    main_oc = 1'b1;
    run_high_main(n);
    main_oc = 1'b0;
    chk("R8 blanking ticks", n, BLANK);
    chk("R8 main off", main_en, 0);
    chk("R8 counted", retry_count, 1);
    wait_main_on;
  endtask

  task automatic t_short;
    int n;
    main_short = 1'b1;
    run_high_main(n);
    main_short = 1'b0;
    chk("R9 short window", n, SHORT - 1);
    chk("R9 counted", retry_count, 2);
    wait_main_on;
  endtask

  task automatic t_tick;
    int n;
    ms_tick = 1'b0;
    main_ov = 1'b1; sb_ov = 1'b1;
    step(10);
    chk("R10 main on without tick", main_en, 1);
    chk("R10 sb on without tick", sb_en, 1);
    chk("R10 no count without tick", retry_count, 2);
    main_ov = 1'b0; sb_ov = 1'b0;
    ms_tick = 1'b1;
    main_ov = 1'b1; step(1); main_ov = 1'b0;
    ms_tick = 1'b0;
    chk("R10 main off", main_en, 0);
    chk("R10 count 3", retry_count, 3);
    step(20);
    chk("R10 interval frozen", main_en, 0);
    ms_tick = 1'b1;
    run_low_main(n);
    chk("R10 interval resumes", n, OFF);
  endtask

  initial begin
    t_reset();
    t_main_fault();
    t_sb_fault();
    t_main_latch();
    t_enable_clear();
    t_sb_latch();
    t_hiccup();
    t_oc_blank();
    t_short();
    t_tick();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog R1-R11 actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule